// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block turns a single input clock into four non-overlapping phase strobes. Each run of four strobes is one instruction cycle. It uses the strobes to drive a two-stage pipeline for a small 8-bit core. It holds the fetch pointer, the program memory address register, a fetch latch and the instruction register. While one instruction executes, the word at the next address is fetched. An instruction that does not branch therefore completes once per instruction cycle.

The execute datapath sits outside this block. It reads the current instruction and is told when to read its operand and when to write its result. When the instruction changes the program flow, it raises a branch request together with a target address. A branch costs two instruction cycles. The word already prefetched is dropped, and a forced NOP with no side effects executes while the target word is fetched. A clock-out pin at a quarter of the input rate lets outside logic follow the instruction cycles.

Top module: `qseq_core`

## Requirements
- R1: Exactly one bit of `q_phase` is high in every clock after reset. The sequence is bit0 (Q1), bit1 (Q2), bit2 (Q3), bit3 (Q4) and repeats. The first clock after reset is Q1.
- R2: `clk_out` is high during Q1 and Q2 and low during Q3 and Q4.
- R3: Synchronous active-high reset sets `pmem_addr` to 0, sets `ir_is_nop` to 1 with `ir_word` 0, and restarts the phases at Q1. The first instruction cycle after reset executes a NOP, and the cycle after it executes the word at address 0.
- R4: `pmem_addr` changes only on the edge that ends Q1. Without a branch, it takes the previous fetch address plus one.
- R5: The word on `pmem_data` at the end of Q4 is captured. It appears on `ir_word` from the edge that ends the following Q1, with `ir_is_nop` 0. `ir_word` does not change on any other edge.
- R6: `rd_stb` is high only in Q2 and `wr_stb` only in Q4 of an execute cycle whose instruction is not a NOP. Both are high there in every such cycle.
- R7: A high `br_req` sampled at the end of Q4 while a non-NOP instruction executes is taken. The next instruction cycle executes a forced NOP (`ir_is_nop`=1, `ir_word`=0, no strobes) and fetches from `br_target`. The cycle after that executes the word at `br_target`.
- R8: `br_req` has no effect when it is sampled in Q1, Q2 or Q3. It also has no effect while a NOP executes. Such requests leave the fetch sequence and the executed instructions unchanged.
- R9: The 12-bit fetch address wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one phase per period |
| rst | input | 1 | Synchronous active-high reset |
| pmem_addr | output | 12 | Program memory word address |
| pmem_data | input | 14 | Instruction word returned by program memory |
| br_req | input | 1 | Branch request from the execute datapath |
| br_target | input | 12 | Branch destination address |
| q_phase | output | 4 | One-hot phase strobes, bit0 = Q1 |
| clk_out | output | 1 | Quarter-rate clock, high in Q1 and Q2 |
| ir_word | output | 14 | Instruction being executed |
| ir_is_nop | output | 1 | Current execute cycle is a NOP |
| rd_stb | output | 1 | Operand read strobe (Q2) |
| wr_stb | output | 1 | Destination write strobe (Q4) |

## Verification
The hardest case to reach from the ports is a branch request that lands in the forced NOP cycle right after a taken branch. It should be ignored, but a faulty flush would chain a second redirect. The stimulus raises branch requests in Q4 with random targets and high probability, so back-to-back requests occur often. A second phase asserts `br_req` at random in every phase to exercise the ignore rules. A behavioural model compares all outputs on every clock. A final branch to near the top of the address space drives the fetch pointer through its wrap.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int NPH  = 4;
  localparam int HALF = NPH / 2;
  localparam int IQ1  = 0;
  localparam int IQ2  = 1;
  localparam int IQ3  = 2;
  localparam int IQ4  = 3;
endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  output logic [NPH-1:0] ph,
  output logic           clk_out
);
  logic [NPH-1:0] ph_nxt;

  // rotate the one-hot phase left by one position
  for (genvar i = 0; i < NPH; i++) begin : g_rot
    assign ph_nxt[i] = ph[(i + NPH - 1) % NPH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= {{(NPH-1){1'b0}}, 1'b1};
      clk_out <= 1'b1;
    end else begin
      ph      <= ph_nxt;
      clk_out <= |ph_nxt[HALF-1:0];
    end
  end
endmodule

// File: rtl/qseq_fetch.sv
module qseq_fetch #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph_q1,
  input  logic              ph_q4,
  input  logic              br_take,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [WORD_W-1:0] pmem_data,
  output logic [ADDR_W-1:0] pmem_addr,
  output logic [WORD_W-1:0] fl_word,
  output logic              fl_valid
);
  logic [ADDR_W-1:0] next_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc   <= '0;
      pmem_addr <= '0;
      fl_word   <= '0;
      fl_valid  <= 1'b0;
    end else begin
      if (ph_q1) begin
        pmem_addr <= next_pc;
        next_pc   <= next_pc + 1'b1;
      end
      if (ph_q4) begin
        if (br_take) begin
          next_pc  <= br_target;
          fl_word  <= '0;
          fl_valid <= 1'b0;
        end else begin
          fl_word  <= pmem_data;
          fl_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qseq_exec.sv
module qseq_exec #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph_q1,
  input  logic              ph_q2,
  input  logic              ph_q4,
  input  logic              br_req,
  input  logic [WORD_W-1:0] fl_word,
  input  logic              fl_valid,
  output logic [WORD_W-1:0] ir_word,
  output logic              ir_is_nop,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              br_take
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_word   <= '0;
      ir_is_nop <= 1'b1;
    end else if (ph_q1) begin
      ir_word   <= fl_word;
      ir_is_nop <= ~fl_valid;
    end
  end

  assign rd_stb  = ph_q2 & ~ir_is_nop;
  assign wr_stb  = ph_q4 & ~ir_is_nop;
  assign br_take = ph_q4 & br_req & ~ir_is_nop;
endmodule

// File: rtl/qseq_core.sv
module qseq_core
  import qseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] pmem_addr,
  input  logic [WORD_W-1:0] pmem_data,
  input  logic              br_req,
  input  logic [ADDR_W-1:0] br_target,
  output logic [NPH-1:0]    q_phase,
  output logic              clk_out,
  output logic [WORD_W-1:0] ir_word,
  output logic              ir_is_nop,
  output logic              rd_stb,
  output logic              wr_stb
);
  logic [NPH-1:0]    ph;
  logic              br_take;
  logic [WORD_W-1:0] fl_word;
  logic              fl_valid;

  qseq_phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph),
    .clk_out (clk_out)
  );

  qseq_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .ph_q1     (ph[IQ1]),
    .ph_q4     (ph[IQ4]),
    .br_take   (br_take),
    .br_target (br_target),
    .pmem_data (pmem_data),
    .pmem_addr (pmem_addr),
    .fl_word   (fl_word),
    .fl_valid  (fl_valid)
  );

  qseq_exec #(.WORD_W(WORD_W)) u_exec (
    .clk       (clk),
    .rst       (rst),
    .ph_q1     (ph[IQ1]),
    .ph_q2     (ph[IQ2]),
    .ph_q4     (ph[IQ4]),
    .br_req    (br_req),
    .fl_word   (fl_word),
    .fl_valid  (fl_valid),
    .ir_word   (ir_word),
    .ir_is_nop (ir_is_nop),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .br_take   (br_take)
  );

  assign q_phase = ph;
endmodule

// File: rtl/qseq_core_chk.sv
module qseq_core_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pmem_addr,
  input logic              br_req,
  input logic [ADDR_W-1:0] br_target,
  input logic [3:0]        q_phase,
  input logic              clk_out,
  input logic [WORD_W-1:0] ir_word,
  input logic              ir_is_nop,
  input logic              rd_stb,
  input logic              wr_stb
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(q_phase) == 1);
  p_q1_to_q2_r1: assert property (@(posedge clk) disable iff (rst)
    q_phase[0] |=> q_phase[1]);
  p_q4_to_q1_r1: assert property (@(posedge clk) disable iff (rst)
    q_phase[3] |=> q_phase[0]);
  p_clkout_r2: assert property (@(posedge clk) disable iff (rst)
    clk_out == (q_phase[0] | q_phase[1]));
  p_reset_r3: assert property (@(posedge clk)
    rst |=> (pmem_addr == '0) && ir_is_nop && (ir_word == '0) && q_phase[0]);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !q_phase[0] |=> $stable(pmem_addr));
  p_ir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !q_phase[0] |=> $stable(ir_word));
  p_rd_r6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> (q_phase[1] && !ir_is_nop));
  p_wr_r6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (q_phase[3] && !ir_is_nop));
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (q_phase[3] && br_req && !ir_is_nop) |=> ##1 (ir_is_nop && pmem_addr == $past(br_target, 2)));
endmodule

bind qseq_core qseq_core_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pmem_addr (pmem_addr),
  .br_req    (br_req),
  .br_target (br_target),
  .q_phase   (q_phase),
  .clk_out   (clk_out),
  .ir_word   (ir_word),
  .ir_is_nop (ir_is_nop),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb)
);

// File: tb/qseq_core_tb.sv
`timescale 1ns/1ps
module qseq_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pmem_addr;
  logic [13:0] pmem_data;
  logic        br_req = 1'b0;
  logic [11:0] br_target = '0;
  logic [3:0]  q_phase;
  logic        clk_out;
  logic [13:0] ir_word;
  logic        ir_is_nop;
  logic        rd_stb;
  logic        wr_stb;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string tag = "R4";

  // behavioural reference state
  int m_p, m_addr, m_next, m_latch, m_ir;
  bit m_lv, m_irn;

  always #2 clk = ~clk;

  function automatic logic [13:0] memf(input int a);
    return 14'(((a * 37) + 5) ^ (a >> 3));
  endfunction

  assign pmem_data = memf(int'(pmem_addr));

  qseq_core u_dut (
    .clk(clk), .rst(rst), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .br_req(br_req), .br_target(br_target), .q_phase(q_phase),
    .clk_out(clk_out), .ir_word(ir_word), .ir_is_nop(ir_is_nop),
    .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_p = 0; m_addr = 0; m_next = 0; m_latch = 0; m_lv = 0; m_ir = 0; m_irn = 1;
  endtask

  task automatic model_step(input bit br, input int tgt);
    bit take;
    take = (m_p == 3) && br && !m_irn;
    if (m_p == 0) begin
      m_ir = m_latch; m_irn = !m_lv;
      m_addr = m_next; m_next = (m_next + 1) % 4096;
    end
    if (m_p == 3) begin
      if (take) begin m_next = tgt; m_lv = 0; m_latch = 0; end
      else begin m_latch = int'(memf(m_addr)); m_lv = 1; end
    end
    m_p = (m_p + 1) % 4;
  endtask

  task automatic compare();
    chk("R1", int'(q_phase), 1 << m_p);
    chk("R2", int'(clk_out), int'(m_p < 2));
    chk(tag, int'(pmem_addr), m_addr);
    chk(tag, int'(ir_word), m_ir);
    chk(tag, int'(ir_is_nop), int'(m_irn));
    chk("R6", int'(rd_stb), int'(m_p == 1 && !m_irn));
    chk("R6", int'(wr_stb), int'(m_p == 3 && !m_irn));
  endtask

  task automatic cycle(input bit br, input int tgt);
    @(negedge clk);
    cyc++;
    compare();
    br_req = br; br_target = 12'(tgt);
    model_step(br, tgt);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; br_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    // R3: reset state seen at the ports
    chk("R3", int'(pmem_addr), 0);
    chk("R3", int'(ir_is_nop), 1);
    chk("R3", int'(ir_word), 0);
    chk("R3", int'(q_phase), 1);
    chk("R3", int'(rd_stb | wr_stb), 0);
    rst = 1'b0;
    model_step(0, 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // R3 R4 R5: reset, then sequential fetch
    tag = "R4";
    do_reset();
    for (int i = 0; i < 60; i++) cycle(0, 0);

    // R7: taken branches in Q4, often back to back
    tag = "R7";
    for (int i = 0; i < 600; i++) begin
      bit b;
      b = (m_p == 3) && ($urandom % 3 != 0);
      cycle(b, int'($urandom % 4096));
    end

    // R8: requests in every phase, including NOP cycles
    tag = "R8";
    for (int i = 0; i < 600; i++) cycle(bit'($urandom % 2), int'($urandom % 4096));

    // R9: branch near the top and run across the wrap
    tag = "R9";
    while (!(m_p == 3 && !m_irn)) cycle(0, 0);
    cycle(1, 4092);
    for (int i = 0; i < 48; i++) cycle(0, 0);

    // R3: reset mid-run
    tag = "R3";
    cycle(0, 0);
    cycle(0, 0);
    do_reset();
    for (int i = 0; i < 16; i++) cycle(0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule